// File: doc/BRIEF.md
# DMA Programming Byte Stream Decoder

This block receives the configuration stream of a DMA controller one byte at a time through a single byte-wide write port. Each byte is either a base byte or a follow byte. A base byte selects one of seven register groups and carries flag bits. Those flags say which optional follow bytes come next. The block collects those follow bytes in their fixed order and updates the stored transfer configuration. It presents that configuration as plain decoded outputs that a separate data-movement engine can use.

Control codes in the command group do not store anything. Each one raises a single-cycle pulse: reset, load, enable, disable, continue or read-mask arm. The read-mask code takes exactly one more byte and keeps it as the readback selection mask. A reset code always abandons a half-collected sequence. This holds even when the code arrives in a follow-byte position, which is the default build. The next byte is then decoded as a base byte.

The input is a valid/ready stream. The decoder consumes one byte per cycle and never applies back-pressure, so `in_ready` stays high. A byte counts only in a cycle where `in_valid` and `in_ready` are both high. Holding `in_valid` low stalls the stream with no side effect.

Top module: `dma_prog_decoder`

## Requirements
- R1: `in_ready` is always high. A byte is consumed only on a clock edge where `in_valid` is high. Data presented while `in_valid` is low changes no output and raises no pulse. Back-to-back bytes on consecutive cycles are each decoded.
- R2: A group-0 base byte (bit7=0, bits1..0 not 00) stores bit2 as direction (1 = A to B) and bits1..0 as the operation code. Bits 3, 4, 5 and 6 announce, in this order, the port A address low and high bytes and the block length low and high bytes. Each 16-bit value is assembled low byte first.
- R3: A group-1 base byte (bit7=0, bits2..0=100) stores bit3 as the port A I/O flag and bits5..4 as its step mode. A group-2 base byte (bit7=0, bits2..0=000) stores the same fields for port B. In either group, bit6 announces one timing byte whose bits1..0 become the cycle code. A group without that byte keeps its previous cycle code.
- R4: In the port B timing byte, bit5 set announces one more byte, stored as the 8-bit prescaler.
- R5: A group-3 base byte (bit7=1, bits1..0=00) stores bit6 run-on-load, bit5 interrupt enable and bit2 stop-on-match. Bit3 announces a mask byte and bit4 a match byte, and the mask byte arrives first.
- R6: A group-4 base byte (bit7=1, bits1..0=01) stores bits6..5 as the transfer mode. Bits 2 and 3 announce the port B address low and high bytes.
- R7: A group-5 base byte (bit7=1, bits2..0=010) stores bit5 as the auto-reload flag.
- R8: A group-6 byte (bit7=1, bits1..0=11) raises exactly one pulse, in the cycle after it is consumed. The codes are C3 reset, CF load, 87 enable, 83 disable, D3 continue and BB read-mask arm. No two pulses are ever high together.
- R9: After BB, exactly one following byte is stored as the read mask, and the byte after it is decoded as a base byte.
- R10: A reset code consumed while follow bytes are still pending drops the rest of that sequence. The next byte is decoded as a base byte, and the values already written stay in place.
- R11: A group-6 code outside the six listed is ignored. It raises no pulse, and the next byte is still decoded as a base byte.
- R12: A base byte that announces fewer follow bytes is followed by exactly that many. The byte after them is decoded as a base byte.
- R13: While `rst_n` is low, every configuration output and every pulse is zero and any pending sequence is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream ready, always high |
| in_data | input | 8 | Stream byte |
| dir_a_to_b | output | 1 | Direction, 1 = A to B |
| op_kind | output | 2 | Operation code from group 0 |
| a_addr | output | 16 | Port A start address |
| blk_len | output | 16 | Block length |
| a_is_io | output | 1 | Port A is I/O |
| a_step | output | 2 | Port A step mode |
| a_cycle | output | 2 | Port A cycle code |
| b_is_io | output | 1 | Port B is I/O |
| b_step | output | 2 | Port B step mode |
| b_cycle | output | 2 | Port B cycle code |
| b_prescale | output | 8 | Port B prescaler |
| run_on_load | output | 1 | Run-on-load flag |
| irq_on_end | output | 1 | Interrupt enable flag |
| stop_on_hit | output | 1 | Stop-on-match flag |
| hit_mask | output | 8 | Match mask byte |
| hit_value | output | 8 | Match value byte |
| xfer_mode | output | 2 | Transfer mode |
| b_addr | output | 16 | Port B start address |
| auto_reload | output | 1 | Auto-reload flag |
| rd_mask | output | 8 | Readback selection mask |
| p_reset | output | 1 | Reset command pulse |
| p_load | output | 1 | Load command pulse |
| p_enable | output | 1 | Enable command pulse |
| p_disable | output | 1 | Disable command pulse |
| p_continue | output | 1 | Continue command pulse |
| p_rdmask | output | 1 | Read-mask arm pulse |

## Verification
The hardest state to reach from the ports is a sequence cut off halfway. One case is a reset code arriving in a follow-byte slot. Another is the prescaler byte, which only becomes pending after the timing byte has been consumed. The stimulus table sends a group-0 base byte that announces four follow bytes, supplies one of them, and then injects the reset code. The next byte is a port B group-2 base byte: if the abort failed, that byte would be taken as an address byte. The table also sends a timing byte with bit5 set and then the prescaler, and the bench checks at the port that the group-2 fields and the port A address come out as expected.

// File: rtl/dmad_pkg.sv
package dmad_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int NSLOT  = 12;
  localparam int SLOT_W = $clog2(NSLOT);

  // Follow-byte slots; the index order is the arrival order inside a group.
  localparam int SL_A_LO   = 0;
  localparam int SL_A_HI   = 1;
  localparam int SL_L_LO   = 2;
  localparam int SL_L_HI   = 3;
  localparam int SL_PA_TIM = 4;
  localparam int SL_PB_TIM = 5;
  localparam int SL_PB_PRE = 6;
  localparam int SL_MASK   = 7;
  localparam int SL_MATCH  = 8;
  localparam int SL_B_LO   = 9;
  localparam int SL_B_HI   = 10;
  localparam int SL_RMASK  = 11;

  localparam logic [BYTE_W-1:0] CODE_RESET = 8'hC3;
  localparam logic [BYTE_W-1:0] CODE_LOAD  = 8'hCF;
  localparam logic [BYTE_W-1:0] CODE_EN    = 8'h87;
  localparam logic [BYTE_W-1:0] CODE_DIS   = 8'h83;
  localparam logic [BYTE_W-1:0] CODE_CONT  = 8'hD3;
  localparam logic [BYTE_W-1:0] CODE_RMASK = 8'hBB;

  typedef logic [NSLOT-1:0] slot_vec_t;

  typedef enum logic [2:0] {
    G_NONE, G_WR0, G_WR1, G_WR2, G_WR3, G_WR4, G_WR5, G_WR6
  } grp_e;

  typedef enum logic [2:0] {
    C_NONE, C_RESET, C_LOAD, C_ENABLE, C_DISABLE, C_CONT, C_RMASK
  } cmd_e;

  typedef struct packed {
    logic              dir_ab;
    logic [1:0]        op;
    logic [HALF_W-1:0] pa_addr;
    logic [HALF_W-1:0] blk_len;
    logic              pa_io;
    logic [1:0]        pa_mode;
    logic [1:0]        pa_cyc;
    logic              pb_io;
    logic [1:0]        pb_mode;
    logic [1:0]        pb_cyc;
    logic [BYTE_W-1:0] pb_presc;
    logic              run_en;
    logic              irq_en;
    logic              stop_hit;
    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] match;
    logic [1:0]        xmode;
    logic [HALF_W-1:0] pb_addr;
    logic              auto_rl;
    logic [BYTE_W-1:0] rd_mask;
  } cfg_t;

  // Follow slots announced by a base byte.
  function automatic slot_vec_t base_slots(grp_e g, logic [BYTE_W-1:0] d, cmd_e c);
    slot_vec_t s;
    s = '0;
    case (g)
      G_WR0: begin
        s[SL_A_LO] = d[3];
        s[SL_A_HI] = d[4];
        s[SL_L_LO] = d[5];
        s[SL_L_HI] = d[6];
      end
      G_WR1: s[SL_PA_TIM] = d[6];
      G_WR2: s[SL_PB_TIM] = d[6];
      G_WR3: begin
        s[SL_MASK]  = d[3];
        s[SL_MATCH] = d[4];
      end
      G_WR4: begin
        s[SL_B_LO] = d[2];
        s[SL_B_HI] = d[3];
      end
      G_WR6: s[SL_RMASK] = (c == C_RMASK);
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dmad_classify.sv
module dmad_classify
  import dmad_pkg::*;
(
  input  logic [BYTE_W-1:0] data,
  output grp_e              grp,
  output cmd_e              cmd
);
  always_comb begin
    grp = G_NONE;
    if (!data[7]) begin
      if (data[1:0] != 2'b00)       grp = G_WR0;
      else if (data[2])             grp = G_WR1;
      else                          grp = G_WR2;
    end else begin
      case (data[1:0])
        2'b00:   grp = G_WR3;
        2'b01:   grp = G_WR4;
        2'b11:   grp = G_WR6;
        default: grp = data[2] ? G_NONE : G_WR5;
      endcase
    end
  end

  always_comb begin
    cmd = C_NONE;
    if (grp == G_WR6) begin
      case (data)
        CODE_RESET: cmd = C_RESET;
        CODE_LOAD:  cmd = C_LOAD;
        CODE_EN:    cmd = C_ENABLE;
        CODE_DIS:   cmd = C_DISABLE;
        CODE_CONT:  cmd = C_CONT;
        CODE_RMASK: cmd = C_RMASK;
        default:    cmd = C_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dmad_parser.sv
module dmad_parser
  import dmad_pkg::*;
#(
  parameter bit RESET_PREEMPTS = 1'b1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [BYTE_W-1:0] data,
  input  grp_e              grp,
  input  cmd_e              cmd,
  output logic              base_we,
  output logic              fol_we,
  output logic [SLOT_W-1:0] fol_slot
);
  slot_vec_t         pend, pend_n;
  logic              busy;
  logic              preempt;
  logic [SLOT_W-1:0] cur;

  assign busy = |pend;

  generate
    if (RESET_PREEMPTS) begin : g_preempt
      assign preempt = (cmd == C_RESET);
    end else begin : g_no_preempt
      assign preempt = 1'b0;
    end
  endgenerate

  always_comb begin
    cur = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (pend[i]) cur = SLOT_W'(i);
    end
  end

  assign base_we  = acc && (!busy || preempt);
  assign fol_we   = acc && busy && !preempt;
  assign fol_slot = cur;

  always_comb begin
    pend_n = pend;
    if (base_we) begin
      pend_n = base_slots(grp, data, cmd);
    end else if (fol_we) begin
      pend_n[cur] = 1'b0;
      if (int'(cur) == SL_PB_TIM && data[5]) pend_n[SL_PB_PRE] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_n;
  end

  // R12
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fol_we && !(int'(cur) == SL_PB_TIM && data[5]))
      |=> ($countones(pend) == $countones($past(pend)) - 1));

  // R4
  presc_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fol_we && int'(cur) == SL_PB_TIM && data[5]) |=> pend[SL_PB_PRE]);

  // R9
  rmask_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && cmd == C_RMASK) |=> (pend == (slot_vec_t'(1) << SL_RMASK)));

  // R10
  reset_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && cmd == C_RESET) |=> (pend == '0));

  // R11
  unknown_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && grp == G_WR6 && cmd == C_NONE) |=> (pend == '0));
endmodule

// File: rtl/dmad_regs.sv
module dmad_regs
  import dmad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  grp_e              grp,
  input  logic              fol_we,
  input  logic [SLOT_W-1:0] fol_slot,
  input  logic [BYTE_W-1:0] data,
  output cfg_t              cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (base_we) begin
      case (grp)
        G_WR0: begin
          cfg.dir_ab <= data[2];
          cfg.op     <= data[1:0];
        end
        G_WR1: begin
          cfg.pa_io   <= data[3];
          cfg.pa_mode <= data[5:4];
        end
        G_WR2: begin
          cfg.pb_io   <= data[3];
          cfg.pb_mode <= data[5:4];
        end
        G_WR3: begin
          cfg.run_en   <= data[6];
          cfg.irq_en   <= data[5];
          cfg.stop_hit <= data[2];
        end
        G_WR4: cfg.xmode   <= data[6:5];
        G_WR5: cfg.auto_rl <= data[5];
        default: ;
      endcase
    end else if (fol_we) begin
      case (int'(fol_slot))
        SL_A_LO:   cfg.pa_addr[BYTE_W-1:0]      <= data;
        SL_A_HI:   cfg.pa_addr[HALF_W-1:BYTE_W] <= data;
        SL_L_LO:   cfg.blk_len[BYTE_W-1:0]      <= data;
        SL_L_HI:   cfg.blk_len[HALF_W-1:BYTE_W] <= data;
        SL_PA_TIM: cfg.pa_cyc                   <= data[1:0];
        SL_PB_TIM: cfg.pb_cyc                   <= data[1:0];
        SL_PB_PRE: cfg.pb_presc                 <= data;
        SL_MASK:   cfg.mask                     <= data;
        SL_MATCH:  cfg.match                    <= data;
        SL_B_LO:   cfg.pb_addr[BYTE_W-1:0]      <= data;
        SL_B_HI:   cfg.pb_addr[HALF_W-1:BYTE_W] <= data;
        SL_RMASK:  cfg.rd_mask                  <= data;
        default: ;
      endcase
    end
  end

  // R2
  a_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fol_we && int'(fol_slot) == SL_A_LO) |=> $stable(cfg.pa_addr[BYTE_W-1:0]));

  // R9
  rd_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fol_we && int'(fol_slot) == SL_RMASK) |=> $stable(cfg.rd_mask));

  // R7
  auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(base_we && grp == G_WR5) |=> $stable(cfg.auto_rl));
endmodule

// File: rtl/dmad_cmd.sv
module dmad_cmd
  import dmad_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic base_we,
  input  cmd_e cmd,
  output logic [5:0] pulses
);
  logic [5:0] pul_n;

  always_comb begin
    pul_n = '0;
    if (base_we) begin
      case (cmd)
        C_RESET:   pul_n[5] = 1'b1;
        C_LOAD:    pul_n[4] = 1'b1;
        C_ENABLE:  pul_n[3] = 1'b1;
        C_DISABLE: pul_n[2] = 1'b1;
        C_CONT:    pul_n[1] = 1'b1;
        C_RMASK:   pul_n[0] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pulses <= '0;
    else        pulses <= pul_n;
  end

  // R8
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(base_we && cmd != C_NONE) |=> (pulses == '0));
endmodule

// File: rtl/dma_prog_decoder.sv
module dma_prog_decoder
  import dmad_pkg::*;
#(
  parameter bit RESET_PREEMPTS = 1'b1
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        dir_a_to_b,
  output logic [1:0]  op_kind,
  output logic [15:0] a_addr,
  output logic [15:0] blk_len,
  output logic        a_is_io,
  output logic [1:0]  a_step,
  output logic [1:0]  a_cycle,
  output logic        b_is_io,
  output logic [1:0]  b_step,
  output logic [1:0]  b_cycle,
  output logic [7:0]  b_prescale,
  output logic        run_on_load,
  output logic        irq_on_end,
  output logic        stop_on_hit,
  output logic [7:0]  hit_mask,
  output logic [7:0]  hit_value,
  output logic [1:0]  xfer_mode,
  output logic [15:0] b_addr,
  output logic        auto_reload,
  output logic [7:0]  rd_mask,
  output logic        p_reset,
  output logic        p_load,
  output logic        p_enable,
  output logic        p_disable,
  output logic        p_continue,
  output logic        p_rdmask
);
  grp_e              grp;
  cmd_e              cmd;
  logic              acc, base_we, fol_we;
  logic [SLOT_W-1:0] fol_slot;
  cfg_t              cfg;
  logic [5:0]        pulses;

  assign in_ready = 1'b1;
  assign acc      = in_valid && in_ready;

  dmad_classify u_cls (.data(in_data), .grp(grp), .cmd(cmd));

  dmad_parser #(.RESET_PREEMPTS(RESET_PREEMPTS)) u_par (
    .clk(clk), .rst_n(rst_n), .acc(acc), .data(in_data), .grp(grp), .cmd(cmd),
    .base_we(base_we), .fol_we(fol_we), .fol_slot(fol_slot)
  );

  dmad_regs u_regs (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .grp(grp), .fol_we(fol_we),
    .fol_slot(fol_slot), .data(in_data), .cfg(cfg)
  );

  dmad_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .cmd(cmd), .pulses(pulses)
  );

  assign dir_a_to_b  = cfg.dir_ab;
  assign op_kind     = cfg.op;
  assign a_addr      = cfg.pa_addr;
  assign blk_len     = cfg.blk_len;
  assign a_is_io     = cfg.pa_io;
  assign a_step      = cfg.pa_mode;
  assign a_cycle     = cfg.pa_cyc;
  assign b_is_io     = cfg.pb_io;
  assign b_step      = cfg.pb_mode;
  assign b_cycle     = cfg.pb_cyc;
  assign b_prescale  = cfg.pb_presc;
  assign run_on_load = cfg.run_en;
  assign irq_on_end  = cfg.irq_en;
  assign stop_on_hit = cfg.stop_hit;
  assign hit_mask    = cfg.mask;
  assign hit_value   = cfg.match;
  assign xfer_mode   = cfg.xmode;
  assign b_addr      = cfg.pb_addr;
  assign auto_reload = cfg.auto_rl;
  assign rd_mask     = cfg.rd_mask;

  assign {p_reset, p_load, p_enable, p_disable, p_continue, p_rdmask} = pulses;

  // R8
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p_reset, p_load, p_enable, p_disable, p_continue, p_rdmask}));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(p_reset || p_load || p_enable || p_disable || p_continue || p_rdmask));
endmodule

// File: tb/dma_prog_decoder_bench.sv
`timescale 1ns/1ps
module dma_prog_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        dir_a_to_b, a_is_io, b_is_io, run_on_load, irq_on_end, stop_on_hit, auto_reload;
  logic [1:0]  op_kind, a_step, a_cycle, b_step, b_cycle, xfer_mode;
  logic [15:0] a_addr, blk_len, b_addr;
  logic [7:0]  b_prescale, hit_mask, hit_value, rd_mask;
  logic        p_reset, p_load, p_enable, p_disable, p_continue, p_rdmask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_prog_decoder u_dma_prog_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .dir_a_to_b(dir_a_to_b), .op_kind(op_kind), .a_addr(a_addr), .blk_len(blk_len),
    .a_is_io(a_is_io), .a_step(a_step), .a_cycle(a_cycle),
    .b_is_io(b_is_io), .b_step(b_step), .b_cycle(b_cycle), .b_prescale(b_prescale),
    .run_on_load(run_on_load), .irq_on_end(irq_on_end), .stop_on_hit(stop_on_hit),
    .hit_mask(hit_mask), .hit_value(hit_value), .xfer_mode(xfer_mode), .b_addr(b_addr),
    .auto_reload(auto_reload), .rd_mask(rd_mask),
    .p_reset(p_reset), .p_load(p_load), .p_enable(p_enable), .p_disable(p_disable),
    .p_continue(p_continue), .p_rdmask(p_rdmask)
  );

  typedef struct packed {
    logic [7:0]  b;
    logic [3:0]  probe;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  // probe: 1 a_addr, 2 blk_len, 3 b_addr, 4 {dir,op}, 5 {a_io,a_step,a_cycle},
  // 6 {b_io,b_step,b_cycle}, 7 prescale, 8 {run,irq,stop}, 9 mask, 10 match,
  // 11 xfer_mode, 12 auto_reload, 13 rd_mask, 14 pulses {rst,load,en,dis,cont,rmask}
  localparam vec_t VECS [NV] = '{
    '{8'h7D, 4'd4,  16'h0005, 4'd2},   // R2 base, four follows
    '{8'h34, 4'd1,  16'h0034, 4'd2},   // R2 low byte first
    '{8'h12, 4'd1,  16'h1234, 4'd2},
    '{8'h20, 4'd2,  16'h0020, 4'd2},
    '{8'h01, 4'd2,  16'h0120, 4'd2},
    '{8'h54, 4'd5,  16'h0004, 4'd3},   // R3 port A base with timing
    '{8'h01, 4'd5,  16'h0005, 4'd3},
    '{8'h68, 4'd6,  16'h0018, 4'd3},   // R3 port B io fixed
    '{8'h21, 4'd6,  16'h0019, 4'd4},   // R4 timing announcing prescaler
    '{8'h32, 4'd7,  16'h0032, 4'd4},
    '{8'h9C, 4'd8,  16'h0001, 4'd5},   // R5 stop flag, mask and match
    '{8'hFF, 4'd9,  16'h00FF, 4'd5},
    '{8'h0A, 4'd10, 16'h000A, 4'd5},
    '{8'hCD, 4'd11, 16'h0002, 4'd6},   // R6 burst, address follows
    '{8'h5B, 4'd3,  16'h005B, 4'd6},
    '{8'hC0, 4'd3,  16'hC05B, 4'd6},
    '{8'hA2, 4'd12, 16'h0001, 4'd7},   // R7
    '{8'hCF, 4'd14, 16'h0010, 4'd8},   // R8 load
    '{8'h87, 4'd14, 16'h0008, 4'd8},   // R8 enable
    '{8'h83, 4'd14, 16'h0004, 4'd8},   // R8 disable
    '{8'hD3, 4'd14, 16'h0002, 4'd8},   // R8 continue
    '{8'hBB, 4'd14, 16'h0001, 4'd9},   // R9 arm
    '{8'h7E, 4'd13, 16'h007E, 4'd9},   // R9 captured, not decoded
    '{8'h82, 4'd4,  16'h0005, 4'd9},   // R9 dir/op untouched by 7E
    '{8'h82, 4'd12, 16'h0000, 4'd7},   // R7 clear
    '{8'h0D, 4'd4,  16'h0005, 4'd12},  // R12 one follow only
    '{8'h77, 4'd1,  16'h1277, 4'd12},
    '{8'h10, 4'd6,  16'h0005, 4'd12},  // R12 decoded as base
    '{8'hAB, 4'd14, 16'h0000, 4'd11},  // R11 unknown code
    '{8'h2C, 4'd5,  16'h0019, 4'd11},  // R11 next is base
    '{8'h7D, 4'd4,  16'h0005, 4'd10},  // R10 start long sequence
    '{8'h99, 4'd1,  16'h1299, 4'd10},
    '{8'hC3, 4'd14, 16'h0020, 4'd10},  // R10 abort
    '{8'h18, 4'd6,  16'h0015, 4'd10},  // R10 decoded as base
    '{8'hE0, 4'd8,  16'h0006, 4'd5}    // R5 run and irq flags
  };

  function automatic logic [15:0] probe_val(int p);
    case (p)
      1:  return a_addr;
      2:  return blk_len;
      3:  return b_addr;
      4:  return {13'd0, dir_a_to_b, op_kind};
      5:  return {11'd0, a_is_io, a_step, a_cycle};
      6:  return {11'd0, b_is_io, b_step, b_cycle};
      7:  return {8'd0, b_prescale};
      8:  return {13'd0, run_on_load, irq_on_end, stop_on_hit};
      9:  return {8'd0, hit_mask};
      10: return {8'd0, hit_value};
      11: return {14'd0, xfer_mode};
      12: return {15'd0, auto_reload};
      13: return {8'd0, rd_mask};
      default: return {10'd0, p_reset, p_load, p_enable, p_disable, p_continue, p_rdmask};
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 pulses", probe_val(14), 16'h0000);
    check("R13 a_addr", a_addr, 16'h0000);
    check("R13 b_addr", b_addr, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 ready
    check("R1 ready", {15'd0, in_ready}, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].b);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), probe_val(int'(VECS[i].probe)), VECS[i].exp);
    end
    // R10 values written before the abort stay
    check("R10 a_addr kept", a_addr, 16'h1299);
    check("R10 blk_len kept", blk_len, 16'h0120);

    // R1 data present but valid low
    @(negedge clk);
    in_data = 8'h87;
    repeat (3) begin
      @(negedge clk);
      check("R1 idle pulses", probe_val(14), 16'h0000);
    end
    check("R1 idle ready", {15'd0, in_ready}, 16'h0001);

    // R1 back-to-back bytes
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'hCF;
    @(negedge clk);
    in_data  = 8'h87;
    check("R1 b2b load", probe_val(14), 16'h0010);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 b2b enable", probe_val(14), 16'h0008);

    // R13 mid-sequence reset
    send(8'h7D);
    send(8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R13 a_addr cleared", a_addr, 16'h0000);
    check("R13 dir/op cleared", probe_val(4), 16'h0000);
    rst_n = 1'b1;
    send(8'h83);
    check("R13 parser idle", probe_val(14), 16'h0004);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule